// File: doc/BRIEF.md
# Serial Memory Page Write Path

This block is the write side of a small serial byte memory. Once the bus front end has accepted a write command, matched the device identity and taken the word address, it hands the address over with a one-cycle strobe. It then delivers each received data byte with its own strobe. The block gathers these bytes in a 16-slot page buffer whose slot pointer starts at the low bits of the word address and wraps inside that page. A page is a 16-byte aligned region.

Nothing reaches the array until the bus Stop arrives. On Stop the block walks the buffer one slot per clock and writes every filled slot into the array. It then holds a timed busy period that stands for the programming time of the cells. While busy is high the front end gives no acknowledge, and this block ignores every input.

A one-time protection fuse can be set by a protect request followed by Stop. That Stop also runs a full busy period. From then on, every byte aimed at the lower half of the array is dropped at commit time, although the bus still accepts it.

Top module: `page_write_buffer`

## Requirements
- R1: A single data byte followed by Stop writes exactly that address and leaves the other 15 bytes of its page unchanged.
- R2: Buffered bytes do not change the array before Stop. After the busy period, each byte lies at {address page, (address offset + byte index) mod 16}.
- R3: A write that runs past offset 15 continues at offset 0 of the same page and never touches the next page. This includes the last page of the array.
- R4: When more than 16 bytes are sent before Stop, each slot holds the last byte written to it, so the earliest bytes are overwritten.
- R5: A Stop with buffered data raises busy in the following cycle. Busy stays high for exactly PAGE + WC_CYCLES cycles.
- R6: While busy is high, the address strobe, byte strobe, Stop and protect request have no effect.
- R7: A Stop with no buffered byte and no pending protect request starts no busy period and writes nothing.
- R8: A protect request followed by Stop sets prot_on, runs a full busy period, and prot_on never clears again.
- R9: With prot_on set, bytes aimed at addresses whose top bit is 0 are discarded at commit, while bytes for the upper half are still written.
- R10: A protect request followed by Stop, once the fuse is already set, starts no busy period.
- R11: After reset, busy, prot_on and mem_we are all 0.
- R12: mem_we is asserted only while busy is high, and the page part of mem_addr stays constant through one busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | Word address strobe; opens a new page session |
| addr_in | input | ADDR_W | Word address |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop | input | 1 | Bus Stop seen; starts the commit |
| prot_req | input | 1 | Protect-fuse command accepted; takes effect at Stop |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data (combinational) |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle running; blocks acknowledges |
| prot_on | output | 1 | Lower-half protection fuse is set |

## Verification
The bench builds the block with ADDR_W = 8 and PAGE = 16, which matches the real array and page size. It shortens WC_CYCLES to 20, so that each busy period lasts 36 cycles and dozens of page writes fit in a short run. With the real geometry, wrapping on the last page and overflow past 16 bytes both happen at true addresses. The short timer lets the bench count the full busy length exactly, and it also leaves enough room to inject stray strobes in the middle of a busy period.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_COMMIT = 2'd1,
    SEQ_HOLD   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int ADDR_W = 8,
  parameter int PAGE   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic                       wr,
  input  logic [7:0]                 wr_data,
  input  logic                       clr,
  input  logic [$clog2(PAGE)-1:0]    rd_slot,
  output logic [ADDR_W-$clog2(PAGE)-1:0] page_o,
  output logic [PAGE-1:0]            valid_o,
  output logic [7:0]                 rd_data
);
  localparam int SW  = $clog2(PAGE);
  localparam int PGW = ADDR_W - SW;

  logic [7:0]     data_q [PAGE];
  logic [PAGE-1:0] valid_q, valid_d;
  logic [SW-1:0]  ptr_q, ptr_d;
  logic [PGW-1:0] page_q, page_d;
  logic           ctl_en;

  // Next-state logic for slot pointer, page and fill mask
  always_comb begin
    valid_d = valid_q;
    ptr_d   = ptr_q;
    page_d  = page_q;
    if (clr) begin
      valid_d = '0;
    end
    if (ld) begin
      valid_d = '0;
      ptr_d   = ld_addr[SW-1:0];
      page_d  = ld_addr[ADDR_W-1:SW];
    end else if (wr) begin
      valid_d[ptr_q] = 1'b1;
      ptr_d          = ptr_q + 1'b1;   // wraps within the page
    end
  end

  assign ctl_en = ld | wr | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
      page_q  <= '0;
    end else if (ctl_en) begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
      page_q  <= page_d;
    end
  end

  // One data register per slot, loaded when the pointer selects it
  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr && !ld && (ptr_q == SW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        data_q[g] <= wr_data;
      end
    end
  end

  assign page_o  = page_q;
  assign valid_o = valid_q;
  assign rd_data = data_q[rd_slot];
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int PAGE      = 16,
  parameter int WC_CYCLES = 500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stop,
  input  logic                    prot_req,
  input  logic                    any_valid,
  output logic                    busy,
  output logic                    committing,
  output logic [$clog2(PAGE)-1:0] slot,
  output logic                    clr,
  output logic                    prot_on
);
  localparam int SW = $clog2(PAGE);
  localparam int CW = $clog2(WC_CYCLES + 1);

  seq_state_e     st_q, st_d;
  logic [SW-1:0]  slot_q, slot_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           pend_q, pend_d;
  logic           fuse_q, fuse_d;
  logic           fuse_go;

  assign fuse_go = pend_q && !fuse_q;

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    fuse_d = fuse_q;
    clr    = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (prot_req) begin
          pend_d = 1'b1;
        end
        if (stop) begin
          pend_d = 1'b0;
          if (any_valid || fuse_go) begin
            st_d   = SEQ_COMMIT;
            slot_d = '0;
          end
          if (fuse_go) begin
            fuse_d = 1'b1;
          end
        end
      end
      SEQ_COMMIT: begin
        slot_d = slot_q + 1'b1;
        if (slot_q == SW'(PAGE - 1)) begin
          st_d  = SEQ_HOLD;
          cnt_d = CW'(WC_CYCLES - 1);
          clr   = 1'b1;
        end
      end
      SEQ_HOLD: begin
        if (cnt_q == '0) begin
          st_d = SEQ_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      slot_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      fuse_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      fuse_q <= fuse_d;
    end
  end

  assign busy       = (st_q != SEQ_IDLE);
  assign committing = (st_q == SEQ_COMMIT);
  assign slot       = slot_q;
  assign prot_on    = fuse_q;
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W    = 8,
  parameter int PAGE      = 16,
  parameter int WC_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              stop,
  input  logic              prot_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              prot_on
);
  localparam int SW  = $clog2(PAGE);
  localparam int PGW = ADDR_W - SW;

  logic            idle;
  logic [PGW-1:0]  page;
  logic [PAGE-1:0] valid;
  logic            buf_any;
  logic            committing;
  logic [SW-1:0]   slot;
  logic            clr;
  logic            prot_hit;

  assign idle    = !busy;
  assign buf_any = |valid;

  pwb_page_buf #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (addr_vld & idle),
    .ld_addr (addr_in),
    .wr      (byte_vld & idle),
    .wr_data (byte_in),
    .clr     (clr),
    .rd_slot (slot),
    .page_o  (page),
    .valid_o (valid),
    .rd_data (mem_wdata)
  );

  pwb_seq #(.PAGE(PAGE), .WC_CYCLES(WC_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop       (stop),
    .prot_req   (prot_req),
    .any_valid  (buf_any),
    .busy       (busy),
    .committing (committing),
    .slot       (slot),
    .clr        (clr),
    .prot_on    (prot_on)
  );

  assign mem_addr = {page, slot};
  assign prot_hit = prot_on && !mem_addr[ADDR_W-1];
  assign mem_we   = committing && valid[slot] && !prot_hit;

  pwb_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int ADDR_W = 8,
  parameter int PAGE   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop,
  input logic              buf_any,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              prot_on
);
  localparam int SW = $clog2(PAGE);

  // R5
  stop_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && buf_any) |=> busy);

  // R12
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R12
  page_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:SW] == $past(mem_addr[ADDR_W-1:SW])));

  // R9
  no_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && prot_on) |-> mem_addr[ADDR_W-1]);

  // R8
  fuse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on |=> prot_on);

  // R8
  fuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> busy);
endmodule

bind page_write_buffer pwb_chk #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop     (stop),
  .buf_any  (buf_any),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .prot_on  (prot_on)
);

// File: tb/test_page_write_buffer.sv
`timescale 1ns/1ps
module test_page_write_buffer;
  localparam int ADDR_W = 8;
  localparam int PAGE   = 16;
  localparam int WC     = 20;
  localparam int BUSY_N = PAGE + WC;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              addr_vld = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              byte_vld = 1'b0;
  logic [7:0]        byte_in = '0;
  logic              stop = 1'b0;
  logic              prot_req = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic              busy;
  logic              prot_on;

  always #2 clk = ~clk;   // 250 MHz

  page_write_buffer #(.ADDR_W(ADDR_W), .PAGE(PAGE), .WC_CYCLES(WC)) i_page_write_buffer (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop(stop), .prot_req(prot_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .prot_on(prot_on)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] ref_mem [256];
  bit         known   [256];
  bit         ref_fuse = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Target address of the k-th byte of a write starting at a
  function automatic logic [7:0] tgt_addr(input logic [7:0] a, input int k);
    logic [3:0] off;
    off = a[3:0] + 4'(k);
    return {a[7:4], off};
  endfunction

  function automatic bit is_blocked(input logic [7:0] a);
    return ref_fuse && !a[7];
  endfunction

  task automatic check_page(input logic [3:0] pg, input string req);
    for (int i = 0; i < PAGE; i++) begin
      logic [7:0] a;
      a = {pg, 4'(i)};
      if (known[a]) begin
        rd_addr = a;
        #0.5;
        chk(rd_data == ref_mem[a], req, rd_data, ref_mem[a]);
      end
    end
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  // Called right after pulse_stop; counts busy cycles
  task automatic measure_busy(output int cnt);
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic send_bytes(input logic [7:0] a, input int n, output logic [7:0] d [32]);
    @(negedge clk); addr_vld = 1'b1; addr_in = a;
    @(negedge clk); addr_vld = 1'b0;
    for (int k = 0; k < n; k++) begin
      d[k] = 8'($urandom);
      byte_vld = 1'b1; byte_in = d[k];
      @(negedge clk);
    end
    byte_vld = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input string req);
    logic [7:0] d [32];
    int cnt;
    send_bytes(a, n, d);
    // R2: nothing committed before Stop
    check_page(a[7:4], "R2");
    if (a[7:4] == 4'hF) check_page(4'h0, "R2");
    pulse_stop();
    chk(busy == 1'b1, "R5", busy, 1);
    measure_busy(cnt);
    chk(cnt == BUSY_N, "R5", cnt, BUSY_N);
    for (int k = 0; k < n; k++) begin
      logic [7:0] t;
      t = tgt_addr(a, k);
      if (!is_blocked(t)) begin
        ref_mem[t] = d[k];
        known[t]   = 1'b1;
      end
    end
    check_page(a[7:4], req);
  endtask

  initial begin
    int cnt;
    logic [7:0] dd [32];
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 1'b0, "R11", busy, 0);
    chk(prot_on == 1'b0, "R11", prot_on, 0);
    chk(mem_we == 1'b0, "R11", mem_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Prefill pages used as neighbours
    do_write(8'h00, 16, "R2");
    do_write(8'h20, 16, "R2");
    do_write(8'h30, 16, "R2");
    do_write(8'h40, 16, "R2");
    do_write(8'h60, 16, "R2");
    do_write(8'hA0, 16, "R2");

    // R1: single byte
    do_write(8'h35, 1, "R1");
    // R3: wrap inside the page, next page untouched
    do_write(8'h3D, 6, "R3");
    check_page(4'h4, "R3");
    // R3: last page wraps to its own start, page 0 untouched
    do_write(8'hFC, 8, "R3");
    check_page(4'h0, "R3");
    // R4: overflow past 16 bytes
    do_write(8'h43, 21, "R4");

    // R6: strobes while busy are ignored
    send_bytes(8'h52, 2, dd);
    pulse_stop();
    for (int k = 0; k < 2; k++) begin
      ref_mem[tgt_addr(8'h52, k)] = dd[k];
      known[tgt_addr(8'h52, k)]   = 1'b1;
    end
    repeat (3) @(negedge clk);
    addr_vld = 1'b1; addr_in = 8'h61;
    @(negedge clk); addr_vld = 1'b0; byte_vld = 1'b1; byte_in = 8'hAA;
    @(negedge clk); byte_vld = 1'b0; prot_req = 1'b1;
    @(negedge clk); prot_req = 1'b0; stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    while (busy) @(negedge clk);
    pulse_stop();
    chk(busy == 1'b0, "R6", busy, 0);
    chk(prot_on == 1'b0, "R6", prot_on, 0);
    check_page(4'h6, "R6");
    check_page(4'h5, "R6");

    // R7: empty Stop
    pulse_stop();
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      if (busy || mem_we) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R7", cnt, 0);

    // Random writes before the fuse
    for (int r = 0; r < 10; r++) begin
      do_write(8'($urandom), 1 + int'($urandom_range(19)), "R2");
    end

    // R8: set the fuse
    @(negedge clk); prot_req = 1'b1;
    @(negedge clk); prot_req = 1'b0;
    pulse_stop();
    chk(busy == 1'b1, "R8", busy, 1);
    measure_busy(cnt);
    chk(cnt == BUSY_N, "R8", cnt, BUSY_N);
    chk(prot_on == 1'b1, "R8", prot_on, 1);
    ref_fuse = 1'b1;

    // R9: lower half dropped, upper half written
    do_write(8'h22, 4, "R9");
    do_write(8'hA6, 4, "R9");

    // R10: second protect request
    @(negedge clk); prot_req = 1'b1;
    @(negedge clk); prot_req = 1'b0;
    pulse_stop();
    chk(busy == 1'b0, "R10", busy, 0);
    chk(prot_on == 1'b1, "R10", prot_on, 1);

    // Random writes after the fuse
    for (int r = 0; r < 10; r++) begin
      do_write(8'($urandom), 1 + int'($urandom_range(19)), "R9");
    end
    chk(prot_on == 1'b1, "R8", prot_on, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule